// File: doc/BRIEF.md
# Cache Hit Access Checker

This block sits behind a cache tag lookup and decides what a single access does to the line it matched. It receives the access command (read or write), the physical address, the access size in bytes and the five status bits of the matched line. From these it works out whether the access is satisfied, what the line's status bits become and how many cycles the access takes to complete. When a line that was brought in by the prefetcher is touched, it can also pulse a training notification back to the prefetcher.

A tag match alone does not make a hit. A write needs a writable line and a read needs a valid line; if that permission is missing, the access is reported as a miss. An access whose byte range runs past the end of the block is flagged as an error and treated as a miss. A lookup-only mode lets the cache probe a line without disturbing it. The tag array, data storage and replacement choice all live in neighbouring blocks.

Every result is registered: a request strobe in one cycle produces a response strobe with all results in the next cycle.

Top module: `hit_access_checker`

## Requirements
- R1: A read is satisfied (`rsp_hit`=1) only when `line_match`=1 and the line's valid bit is set. A write is satisfied only when `line_match`=1 and the writable bit is set. Status vector encoding on `line_status` and `rsp_status`: bit0 valid, bit1 writable, bit2 dirty, bit3 prefetched, bit4 compressed. `req_write`=1 means write, 0 means read.
- R2: A tag match whose permission check fails gives `rsp_hit`=0; the valid, writable, dirty and compressed bits are returned unchanged.
- R3: A satisfied write that is not lookup-only returns the dirty bit (bit2) set; a read never changes the dirty bit.
- R4: Any tag-matched access that is neither lookup-only nor out of range returns the prefetched bit (bit3) cleared, whether or not the permission check passes. Without a tag match the bit is returned unchanged.
- R5: `pf_notify` is high for exactly the response cycle when the access matched a line with the prefetched bit set, `pf_train_en`=1, the access is not lookup-only and the range check passed; otherwise it stays low.
- R6: `rsp_latency` equals `hit_latency` plus `comp_latency` divided by four (rounded down) when the access is satisfied on a line with the compressed bit set, and equals `hit_latency` for every other access that is not lookup-only, misses included.
- R7: `rsp_offset` is the low log2(BLK_BYTES) bits of `req_addr`. When offset plus `req_size` exceeds BLK_BYTES, `rsp_range_err`=1, `rsp_hit`=0, `pf_notify`=0 and the status is returned unchanged; an access that ends exactly on the block boundary is legal.
- R8: When `lookup_only`=1, `rsp_latency`=0, the status is returned unchanged and `pf_notify`=0, while `rsp_hit` still follows R1 and R7.
- R9: `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high and low otherwise; after reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Physical address of the access |
| req_size | input | log2(BLK_BYTES)+1 | Access size in bytes |
| line_match | input | 1 | Tag lookup found the line |
| line_status | input | 5 | Matched line status (bit0 valid .. bit4 compressed) |
| lookup_only | input | 1 | Probe without latency or status update |
| pf_train_en | input | 1 | Enable prefetcher training on prefetched-line hits |
| hit_latency | input | LAT_W | Base lookup latency in cycles |
| comp_latency | input | LAT_W | Decompression latency in cycles |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Access satisfied |
| rsp_offset | output | log2(BLK_BYTES) | Byte offset within the block |
| rsp_status | output | 5 | Updated line status |
| rsp_latency | output | LAT_W+1 | Access latency in cycles |
| rsp_range_err | output | 1 | Byte range runs past the block end |
| pf_notify | output | 1 | One-cycle training pulse to the prefetcher |

## Verification
A wrong internal decision shows at the ports in the response cycle right after the request: a permission slip appears as `rsp_hit` disagreeing with the command and the writable or valid bit, and a bad status update appears as a dirty or prefetched bit in `rsp_status` that differs from the input. Latency errors show as a value off by the quarter of the decompression latency, and a stray or stuck notification shows as `pf_notify` high in an idle cycle. Because nothing is stored across requests beyond the registered response, every fault is visible within one cycle and cannot hide until a later access.

// File: rtl/hac_pkg.sv
package hac_pkg;

    // Line status; packed so that bit0 is valid and bit4 is compressed.
    typedef struct packed {
        logic compressed;
        logic prefetched;
        logic dirty;
        logic writable;
        logic valid;
    } line_st_t;

    localparam int unsigned ST_W = $bits(line_st_t);

endpackage

// File: rtl/hac_range.sv
// Checks that the byte range of an access stays inside one block.
module hac_range #(
    parameter int unsigned BLK_BYTES = 64,
    localparam int unsigned OFF_W    = $clog2(BLK_BYTES),
    localparam int unsigned SIZE_W   = OFF_W + 1
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [SIZE_W-1:0] size,
    output logic              in_range
);
    localparam int unsigned SUM_W = SIZE_W + 1;

    logic [SUM_W-1:0] end_byte;

    always_comb begin
        end_byte = SUM_W'(offset) + SUM_W'(size);
        in_range = (end_byte <= SUM_W'(BLK_BYTES));
    end
endmodule

// File: rtl/hac_perm.sv
// Permission check: writes need a writable line, reads a valid one.
module hac_perm
    import hac_pkg::*;
(
    input  logic     is_write,
    input  logic     match,
    input  line_st_t st,
    output logic     perm_ok
);
    always_comb begin
        if (!match) begin
            perm_ok = 1'b0;
        end else if (is_write) begin
            perm_ok = st.writable;
        end else begin
            perm_ok = st.valid;
        end
    end
endmodule

// File: rtl/hac_status_upd.sv
// Computes the updated line status and the prefetched-line touch flag.
module hac_status_upd
    import hac_pkg::*;
(
    input  line_st_t st_in,
    input  logic     match,
    input  logic     satisfied,
    input  logic     is_write,
    input  logic     lookup,
    input  logic     range_ok,
    output line_st_t st_out,
    output logic     pf_touch
);
    logic may_update;

    always_comb begin
        may_update = match && !lookup && range_ok;
        st_out     = st_in;
        pf_touch   = may_update && st_in.prefetched;
        if (may_update) begin
            st_out.prefetched = 1'b0;
            if (satisfied && is_write) begin
                st_out.dirty = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hac_latency.sv
// Access latency: base plus a quarter of the decompression time on
// satisfied compressed lines, zero for lookup-only probes.
module hac_latency #(
    parameter int unsigned LAT_W = 8
) (
    input  logic [LAT_W-1:0] base_lat,
    input  logic [LAT_W-1:0] comp_lat,
    input  logic             lookup,
    input  logic             satisfied,
    input  logic             compressed,
    output logic [LAT_W:0]   lat
);
    logic [LAT_W:0] extra;

    always_comb begin
        extra = (satisfied && compressed) ? (LAT_W+1)'(comp_lat >> 2) : '0;
        if (lookup) begin
            lat = '0;
        end else begin
            lat = (LAT_W+1)'(base_lat) + extra;
        end
    end
endmodule

// File: rtl/hit_access_checker.sv
module hit_access_checker
    import hac_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BLK_BYTES = 64,
    parameter int unsigned LAT_W     = 8,
    localparam int unsigned OFF_W    = $clog2(BLK_BYTES),
    localparam int unsigned SIZE_W   = OFF_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic                line_match,
    input  logic [ST_W-1:0]     line_status,
    input  logic                lookup_only,
    input  logic                pf_train_en,
    input  logic [LAT_W-1:0]    hit_latency,
    input  logic [LAT_W-1:0]    comp_latency,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [OFF_W-1:0]    rsp_offset,
    output logic [ST_W-1:0]     rsp_status,
    output logic [LAT_W:0]      rsp_latency,
    output logic                rsp_range_err,
    output logic                pf_notify
);

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [OFF_W-1:0] offset;
        line_st_t         status;
        logic [LAT_W:0]   latency;
        logic             range_err;
        logic             notify;
    } rsp_t;

    line_st_t         st_in;
    line_st_t         st_new;
    logic [OFF_W-1:0] offset;
    logic             range_ok;
    logic             perm_ok;
    logic             satisfied;
    logic             pf_touch;
    logic [LAT_W:0]   lat;
    logic             addr_hi_unused;
    rsp_t             rsp_d, rsp_q;

    assign st_in          = line_st_t'(line_status);
    assign offset         = req_addr[OFF_W-1:0];
    assign addr_hi_unused = ^req_addr[ADDR_W-1:OFF_W];
    assign satisfied      = perm_ok && range_ok;

    hac_range #(.BLK_BYTES(BLK_BYTES)) u_range (
        .offset   (offset),
        .size     (req_size),
        .in_range (range_ok)
    );

    hac_perm u_perm (
        .is_write (req_write),
        .match    (line_match),
        .st       (st_in),
        .perm_ok  (perm_ok)
    );

    hac_status_upd u_status (
        .st_in     (st_in),
        .match     (line_match),
        .satisfied (satisfied),
        .is_write  (req_write),
        .lookup    (lookup_only),
        .range_ok  (range_ok),
        .st_out    (st_new),
        .pf_touch  (pf_touch)
    );

    hac_latency #(.LAT_W(LAT_W)) u_lat (
        .base_lat   (hit_latency),
        .comp_lat   (comp_latency),
        .lookup     (lookup_only),
        .satisfied  (satisfied),
        .compressed (st_in.compressed),
        .lat        (lat)
    );

    always_comb begin
        rsp_d        = rsp_q;
        rsp_d.valid  = req_valid;
        rsp_d.notify = 1'b0;
        if (req_valid) begin
            rsp_d.hit       = satisfied;
            rsp_d.offset    = offset;
            rsp_d.status    = st_new;
            rsp_d.latency   = lat;
            rsp_d.range_err = !range_ok;
            rsp_d.notify    = pf_touch && pf_train_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_hit       = rsp_q.hit;
    assign rsp_offset    = rsp_q.offset;
    assign rsp_status    = rsp_q.status;
    assign rsp_latency   = rsp_q.latency;
    assign rsp_range_err = rsp_q.range_err;
    assign pf_notify     = rsp_q.notify;

endmodule

// File: rtl/hac_checker.sv
module hac_checker #(
    parameter int unsigned LAT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             line_match,
    input logic [4:0]       line_status,
    input logic             lookup_only,
    input logic             pf_train_en,
    input logic [LAT_W-1:0] hit_latency,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [4:0]       rsp_status,
    input logic [LAT_W:0]   rsp_latency,
    input logic             rsp_range_err,
    input logic             pf_notify
);
    p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    p_notify_in_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pf_notify |-> rsp_valid);

    p_write_perm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && $past(req_write)) |-> $past(line_match && line_status[1]));

    p_read_perm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && !$past(req_write)) |-> $past(line_match && line_status[0]));

    p_perm_fail_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(line_match && req_write && !line_status[1])) |-> !rsp_hit);

    p_dirty_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && $past(req_write && !lookup_only)) |-> rsp_status[2]);

    p_pf_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_range_err && $past(line_match && !lookup_only)) |-> !rsp_status[3]);

    p_notify_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_notify |-> $past(line_match && line_status[3] && pf_train_en && !lookup_only));

    p_miss_base_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !$past(lookup_only))
            |-> (rsp_latency == (LAT_W+1)'($past(hit_latency))));

    p_range_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_range_err)
            |-> (!rsp_hit && !pf_notify && rsp_status == $past(line_status)));

    p_lookup_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(lookup_only))
            |-> (rsp_latency == '0 && rsp_status == $past(line_status) && !pf_notify));
endmodule

bind hit_access_checker hac_checker #(.LAT_W(LAT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .line_match    (line_match),
    .line_status   (line_status),
    .lookup_only   (lookup_only),
    .pf_train_en   (pf_train_en),
    .hit_latency   (hit_latency),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_status    (rsp_status),
    .rsp_latency   (rsp_latency),
    .rsp_range_err (rsp_range_err),
    .pf_notify     (pf_notify)
);

// File: tb/sim_hit_access_checker.sv
module sim_hit_access_checker;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int BLK_BYTES  = 64;
    localparam int LAT_W      = 8;
    localparam int OFF_W      = 6;
    localparam int SIZE_W     = 7;
    localparam logic [LAT_W-1:0] BASE = 8'd3;
    localparam logic [LAT_W-1:0] COMP = 8'd10;   // quarter = 2

    typedef struct packed {
        logic        wr;
        logic        match;
        logic [31:0] addr;
        logic [6:0]  size;
        logic [4:0]  st;
        logic        lk;
        logic        tr;
        logic        e_hit;
        logic [4:0]  e_st;
        logic [8:0]  e_lat;
        logic        e_err;
        logic        e_pf;
    } vec_t;

    // status bits: {compressed, prefetched, dirty, writable, valid}
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 32'h1000_0040, 7'd8,  5'b00001, 1'b0, 1'b0, 1'b1, 5'b00001, 9'd3, 1'b0, 1'b0}, // R1 read hit
        '{1'b1, 1'b1, 32'h1000_0088, 7'd8,  5'b00011, 1'b0, 1'b0, 1'b1, 5'b00111, 9'd3, 1'b0, 1'b0}, // R3 write dirty
        '{1'b1, 1'b1, 32'h2000_0010, 7'd4,  5'b00001, 1'b0, 1'b0, 1'b0, 5'b00001, 9'd3, 1'b0, 1'b0}, // R2 write no perm
        '{1'b0, 1'b1, 32'h2000_0020, 7'd4,  5'b00000, 1'b0, 1'b0, 1'b0, 5'b00000, 9'd3, 1'b0, 1'b0}, // R2 read invalid
        '{1'b0, 1'b1, 32'h3000_0004, 7'd4,  5'b01001, 1'b0, 1'b1, 1'b1, 5'b00001, 9'd3, 1'b0, 1'b1}, // R4 R5 train
        '{1'b0, 1'b1, 32'h3000_0008, 7'd4,  5'b01001, 1'b0, 1'b0, 1'b1, 5'b00001, 9'd3, 1'b0, 1'b0}, // R5 no train
        '{1'b1, 1'b1, 32'h3000_000C, 7'd4,  5'b01001, 1'b0, 1'b1, 1'b0, 5'b00001, 9'd3, 1'b0, 1'b1}, // R4 perm fail
        '{1'b0, 1'b1, 32'h4000_0000, 7'd8,  5'b10001, 1'b0, 1'b0, 1'b1, 5'b10001, 9'd5, 1'b0, 1'b0}, // R6 compressed
        '{1'b1, 1'b1, 32'h4000_0010, 7'd8,  5'b10011, 1'b0, 1'b0, 1'b1, 5'b10111, 9'd5, 1'b0, 1'b0}, // R6 comp write
        '{1'b1, 1'b1, 32'h4000_0018, 7'd8,  5'b10001, 1'b0, 1'b0, 1'b0, 5'b10001, 9'd3, 1'b0, 1'b0}, // R6 comp miss
        '{1'b0, 1'b1, 32'h5000_003C, 7'd4,  5'b00001, 1'b0, 1'b0, 1'b1, 5'b00001, 9'd3, 1'b0, 1'b0}, // R7 exact end
        '{1'b0, 1'b1, 32'h5000_007C, 7'd5,  5'b01001, 1'b0, 1'b1, 1'b0, 5'b01001, 9'd3, 1'b1, 1'b0}, // R7 overrun
        '{1'b0, 1'b0, 32'h6000_0000, 7'd4,  5'b00001, 1'b0, 1'b0, 1'b0, 5'b00001, 9'd3, 1'b0, 1'b0}, // R1 no match
        '{1'b1, 1'b1, 32'h6000_0020, 7'd4,  5'b01011, 1'b1, 1'b1, 1'b1, 5'b01011, 9'd0, 1'b0, 1'b0}, // R8 lookup write
        '{1'b0, 1'b1, 32'h6000_0024, 7'd4,  5'b10001, 1'b1, 1'b0, 1'b1, 5'b10001, 9'd0, 1'b0, 1'b0}, // R8 lookup comp
        '{1'b0, 1'b1, 32'h7000_0000, 7'd64, 5'b00001, 1'b0, 1'b0, 1'b1, 5'b00001, 9'd3, 1'b0, 1'b0}, // R7 full block
        '{1'b0, 1'b0, 32'h7000_0030, 7'd4,  5'b01001, 1'b0, 1'b1, 1'b0, 5'b01001, 9'd3, 1'b0, 1'b0}  // R4 no match
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [SIZE_W-1:0] req_size = '0;
    logic              line_match = 1'b0;
    logic [4:0]        line_status = '0;
    logic              lookup_only = 1'b0;
    logic              pf_train_en = 1'b0;
    logic [LAT_W-1:0]  hit_latency = BASE;
    logic [LAT_W-1:0]  comp_latency = COMP;
    logic              rsp_valid, rsp_hit, rsp_range_err, pf_notify;
    logic [OFF_W-1:0]  rsp_offset;
    logic [4:0]        rsp_status;
    logic [LAT_W:0]    rsp_latency;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hit_access_checker #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .LAT_W(LAT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .line_match(line_match),
        .line_status(line_status), .lookup_only(lookup_only), .pf_train_en(pf_train_en),
        .hit_latency(hit_latency), .comp_latency(comp_latency), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_offset(rsp_offset), .rsp_status(rsp_status),
        .rsp_latency(rsp_latency), .rsp_range_err(rsp_range_err), .pf_notify(pf_notify)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid   = 1'b1;
        req_write   = v.wr;
        req_addr    = v.addr;
        req_size    = v.size;
        line_match  = v.match;
        line_status = v.st;
        lookup_only = v.lk;
        pf_train_en = v.tr;
    endtask

    task automatic check_vec(input string req, input vec_t v);
        chk(req, "rsp_valid",  32'(rsp_valid),     32'd1);
        chk(req, "hit",        32'(rsp_hit),       32'(v.e_hit));
        chk(req, "status",     32'(rsp_status),    32'(v.e_st));
        chk(req, "latency",    32'(rsp_latency),   32'(v.e_lat));
        chk(req, "range_err",  32'(rsp_range_err), 32'(v.e_err));
        chk(req, "pf_notify",  32'(pf_notify),     32'(v.e_pf));
        chk("R7", "offset",    32'(rsp_offset),    32'(v.addr[5:0]));
    endtask

    initial begin
        // reset state (R9)
        repeat (3) @(negedge clk);
        chk("R9", "reset rsp_valid", 32'(rsp_valid),   32'd0);
        chk("R9", "reset hit",       32'(rsp_hit),     32'd0);
        chk("R9", "reset latency",   32'(rsp_latency), 32'd0);
        chk("R9", "reset notify",    32'(pf_notify),   32'd0);
        chk("R9", "reset status",    32'(rsp_status),  32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: request at one negedge, result after the next posedge
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            req_valid = 1'b0;
            check_vec($sformatf("vec%0d", i), VECS[i]);
            @(negedge clk);
            // idle cycle: no response, notification was a single pulse (R9 R5)
            chk("R9", "idle rsp_valid", 32'(rsp_valid), 32'd0);
            chk("R5", "idle pf_notify", 32'(pf_notify), 32'd0);
        end

        // back-to-back requests (R9, R3, R5)
        drive(VECS[4]);
        @(negedge clk);
        check_vec("R5 b2b first", VECS[4]);
        drive(VECS[1]);
        @(negedge clk);
        check_vec("R3 b2b second", VECS[1]);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9", "after b2b rsp_valid", 32'(rsp_valid), 32'd0);

        // compression latency rounding: comp 7 -> quarter 1 (R6)
        comp_latency = 8'd7;
        drive(VECS[7]);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6", "latency comp7", 32'(rsp_latency), 32'd4);
        comp_latency = COMP;
        @(negedge clk);

        // mid-run reset clears outputs (R9)
        drive(VECS[0]);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R9", "reset again valid", 32'(rsp_valid), 32'd0);
        chk("R9", "reset again hit",   32'(rsp_hit),   32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule